// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the register side of an SPI master controller. A 32-bit register port decodes word-aligned accesses to seven registers: receive data, transmit data, control, configuration, interrupt enable, status and message. It owns a transmit FIFO and a receive FIFO, and it derives live status flags from their fill levels. It drives a level interrupt and four active-low chip selects.

The block decides when a transfer begins. Once a transfer is active, it hands transmit words to a separate burst engine over a valid/ready stream. The engine returns one receive word and a `xfer_done` pulse for each burst. The engine does all serial shifting; this block never shifts bits itself.

On the transmit stream, `tx_word_valid` rises only while a transfer is active and the TX FIFO holds data. While `tx_word_ready` is low, the presented word stays stable, so the engine may hold off for any number of cycles. The receive return path has no back-pressure. A word that arrives while the RX FIFO is full is lost, and the block records an overflow.

Top module: `spim_csr_front`

## Requirements
- R1: The register index is `bus_addr[11:2]`: 0 receive data, 1 transmit data, 2 control, 3 configuration, 4 interrupt enable, 5 status, 6 message. An access is ignored, reads back 0 and raises `bus_err` with `bus_rvalid` one cycle later if any of these hold: the index is 7 or more, `bus_addr[1:0]` is non-zero, or `bus_be` is not 4'hF.
- R2: After reset, status reads 0x00000003, `cs_n` is 4'hF, `irq` is low and the control register reads 0.
- R3: Status bits are live. Bit 0 means TX FIFO empty, bit 1 means TX FIFO not full, bit 2 means TX FIFO full, bit 3 means RX FIFO not empty, and bit 4 means RX FIFO full.
- R4: `irq` is high exactly when some bit of (status AND interrupt enable) is set.
- R5: Status bit 5 (RX overflow) and bit 6 (transfer complete) clear when a 1 is written to them. Writes to every other status bit have no effect.
- R6: A transmit data write is dropped while control bit 0 (enable) is clear or while the TX FIFO is full.
- R7: Reads of transmit data and message return 0. A read of receive data returns 0 while disabled. Otherwise it pops the RX FIFO and returns the oldest word, or 0 if the FIFO is empty.
- R8: Writing the control register with bit 0 clear resets every register and empties both FIFOs.
- R9: Control bits [7:4] mark which channels are masters, and bits [9:8] select a channel. When a control write makes the selected channel a master, that channel's `cs_n` bit goes low and the other three go high.
- R10: While the channel is a master and control bit 2 (immediate mode) is set, an accepted transmit data write starts a transfer.
- R11: An enabled control write that raises bit 2 from 0 to 1 on a master channel starts a transfer when the TX FIFO is not empty.
- R12: An enabled control write that raises bit 1 (exchange) from 0 to 1 on a master channel, with bit 2 clear, starts a transfer.
- R13: During a transfer, TX words leave in write order on the valid/ready stream, and `burst_bits` equals control bits [21:10] plus 1. Each `xfer_done` sets status bit 6. A `xfer_done` that arrives with the TX FIFO empty ends the transfer and clears control bit 1.
- R14: A receive word that arrives while the RX FIFO is full is dropped, and it sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Access response, one cycle after request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Access was rejected |
| irq | output | 1 | Level interrupt |
| cs_n | output | 4 | Active-low chip selects |
| xfer_start | output | 1 | One-cycle pulse when a transfer starts |
| burst_bits | output | 13 | Burst length in bits for the engine |
| tx_word_valid | output | 1 | TX word offered to engine |
| tx_word_ready | input | 1 | Engine takes the TX word |
| tx_word_data | output | 32 | TX word |
| rx_word_valid | input | 1 | Engine returns a received word |
| rx_word_data | input | 32 | Received word |
| xfer_done | input | 1 | Engine finished one burst |

## Verification
The bench builds the block with both FIFOs four words deep. This makes full, drop-on-full and receive overflow reachable within a handful of writes. A model in the bench predicts the status word after random batches of transmit writes. Directed cases then cover all three start conditions, write-one-to-clear behaviour, chip-select steering and reset through the enable bit. A small engine model in the bench returns the inverse of each word.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    IDX_RX   = 3'd0,
    IDX_TX   = 3'd1,
    IDX_CTRL = 3'd2,
    IDX_CONF = 3'd3,
    IDX_IEN  = 3'd4,
    IDX_STAT = 3'd5,
    IDX_MSG  = 3'd6
  } reg_idx_e;

  localparam int ST_TXE = 0;
  localparam int ST_TXS = 1;
  localparam int ST_TXF = 2;
  localparam int ST_RXR = 3;
  localparam int ST_RXF = 4;
  localparam int ST_RXO = 5;
  localparam int ST_TC  = 6;
  localparam int STAT_W = 7;

  typedef struct packed {
    logic [9:0]  rsvd_hi;
    logic [11:0] blen_m1;
    logic [1:0]  sel;
    logic [3:0]  mstr;
    logic        rsvd_lo;
    logic        smc;
    logic        xch;
    logic        en;
  } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign count   = cnt;
  assign rdata   = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spim_start_ctl.sv
module spim_start_ctl (
  input  logic tx_push,
  input  logic tx_empty,
  input  logic wr_ctrl,
  input  logic cur_master,
  input  logic cur_smc,
  input  logic cur_xch,
  input  logic new_en,
  input  logic new_master,
  input  logic new_smc,
  input  logic new_xch,
  output logic start_req
);
  logic by_push, by_smc, by_xch, ctrl_go;

  assign ctrl_go   = wr_ctrl && new_en && new_master;
  assign by_push   = tx_push && cur_master && cur_smc;
  assign by_smc    = ctrl_go && new_smc && !cur_smc && !tx_empty;
  assign by_xch    = ctrl_go && new_xch && !cur_xch && !new_smc;
  assign start_req = by_push || by_smc || by_xch;
endmodule

// File: rtl/spim_csr_front.sv
module spim_csr_front
  import spim_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  parameter int NCS     = 4,
  parameter int BLEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  output logic              irq,
  output logic [NCS-1:0]    cs_n,
  output logic              xfer_start,
  output logic [BLEN_W:0]   burst_bits,
  output logic              tx_word_valid,
  input  logic              tx_word_ready,
  output logic [DW-1:0]     tx_word_data,
  input  logic              rx_word_valid,
  input  logic [DW-1:0]     rx_word_data,
  input  logic              xfer_done
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int TCW   = $clog2(TX_DEPTH+1);
  localparam int RCW   = $clog2(RX_DEPTH+1);

  ctrl_t            ctrl_q, ctrl_new;
  logic [DW-1:0]    conf_q, ien_q;
  logic             ovf_q, tc_q, active_q;
  logic [IDX_W-1:0] idx;
  logic             acc_ok, wr, rd, wr_ctrl, soft_rst;
  logic             tx_push, tx_pop, rx_push, rx_pop;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [DW-1:0]    rx_head;
  logic [TCW-1:0]   tx_cnt;
  logic [RCW-1:0]   rx_cnt;
  logic             start_req, cur_master, new_master;
  logic [STAT_W-1:0] stat_vec;
  logic [DW-1:0]    rd_mux;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign acc_ok   = (bus_addr[1:0] == 2'b00) && (&bus_be) && (idx < IDX_W'(NUM_REGS));
  assign wr       = bus_req && acc_ok && bus_we;
  assign rd       = bus_req && acc_ok && !bus_we;
  assign ctrl_new = ctrl_t'(bus_wdata);
  assign wr_ctrl  = wr && (idx == IDX_W'(IDX_CTRL));
  assign soft_rst = wr_ctrl && !ctrl_new.en;

  assign cur_master = ctrl_q.mstr[ctrl_q.sel];
  assign new_master = ctrl_new.mstr[ctrl_new.sel];

  assign tx_push = wr && (idx == IDX_W'(IDX_TX)) && ctrl_q.en && !tx_full;
  assign tx_pop  = tx_word_valid && tx_word_ready;
  assign rx_pop  = rd && (idx == IDX_W'(IDX_RX)) && ctrl_q.en && !rx_empty;
  assign rx_push = rx_word_valid && !rx_full;

  spim_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .flush(soft_rst), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_word_data), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full));

  spim_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(soft_rst), .push(rx_push), .wdata(rx_word_data),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full));

  spim_start_ctl u_start (
    .tx_push, .tx_empty, .wr_ctrl, .cur_master,
    .cur_smc(ctrl_q.smc), .cur_xch(ctrl_q.xch),
    .new_en(ctrl_new.en), .new_master,
    .new_smc(ctrl_new.smc), .new_xch(ctrl_new.xch), .start_req);

  always_comb begin
    stat_vec         = '0;
    stat_vec[ST_TXE] = tx_empty;
    stat_vec[ST_TXS] = !tx_full;
    stat_vec[ST_TXF] = tx_full;
    stat_vec[ST_RXR] = !rx_empty;
    stat_vec[ST_RXF] = rx_full;
    stat_vec[ST_RXO] = ovf_q;
    stat_vec[ST_TC]  = tc_q;
  end

  assign irq           = |(stat_vec & ien_q[STAT_W-1:0]);
  assign tx_word_valid = active_q && !tx_empty;
  assign burst_bits    = {1'b0, ctrl_q.blen_m1} + 1'b1;

  always_comb begin
    rd_mux = '0;
    if (rd) begin
      unique case (idx[2:0])
        IDX_RX:   rd_mux = rx_pop ? rx_head : '0;
        IDX_CTRL: rd_mux = DW'(ctrl_q);
        IDX_CONF: rd_mux = conf_q;
        IDX_IEN:  rd_mux = ien_q;
        IDX_STAT: rd_mux = DW'(stat_vec);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_rvalid <= bus_req;
      bus_err    <= bus_req && !acc_ok;
      bus_rdata  <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; conf_q <= '0; ien_q <= '0;
      ovf_q <= 1'b0; tc_q <= 1'b0; active_q <= 1'b0;
      cs_n <= '1; xfer_start <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q <= '0; conf_q <= '0; ien_q <= '0;
      ovf_q <= 1'b0; tc_q <= 1'b0; active_q <= 1'b0;
      cs_n <= '1; xfer_start <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_new;
        if (new_master) cs_n <= ~(NCS'(1) << ctrl_new.sel);
      end
      if (wr && idx == IDX_W'(IDX_CONF)) conf_q <= bus_wdata;
      if (wr && idx == IDX_W'(IDX_IEN))  ien_q  <= bus_wdata;
      if (wr && idx == IDX_W'(IDX_STAT)) begin
        if (bus_wdata[ST_RXO]) ovf_q <= 1'b0;
        if (bus_wdata[ST_TC])  tc_q  <= 1'b0;
      end
      if (rx_word_valid && rx_full) ovf_q <= 1'b1;
      if (xfer_done && active_q) begin
        tc_q <= 1'b1;
        if (tx_empty && !start_req) begin
          active_q   <= 1'b0;
          ctrl_q.xch <= 1'b0;
        end
      end
      if (start_req) active_q <= 1'b1;
      xfer_start <= start_req;
    end
  end
endmodule

// File: rtl/spim_csr_checks.sv
module spim_csr_checks #(
  parameter int DW = 32,
  parameter int NCS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          tx_word_valid,
  input logic          tx_word_ready,
  input logic [DW-1:0] tx_word_data,
  input logic          rx_word_valid,
  input logic [6:0]    stat_vec,
  input logic [NCS-1:0] cs_n
);
  // R13: an offered word is held until taken
  a_r13_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid && !tx_word_ready && !soft_rst |=> tx_word_valid && $stable(tx_word_data));

  // R3: a word is never offered while status says TX empty
  a_r3_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid |-> !stat_vec[0]);

  // R3: empty and full flags never coexist
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_vec[0] && stat_vec[2]));

  // R9: at most one chip select low
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R14: a word arriving at a full RX FIFO raises overflow
  a_r14_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid && stat_vec[4] && !soft_rst |=> stat_vec[5]);
endmodule

bind spim_csr_front spim_csr_checks #(.DW(DW), .NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .tx_word_valid(tx_word_valid), .tx_word_ready(tx_word_ready),
  .tx_word_data(tx_word_data), .rx_word_valid(rx_word_valid),
  .stat_vec(stat_vec), .cs_n(cs_n));

// File: tb/spim_csr_front_bench.sv
module spim_csr_front_bench;
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid, bus_err, irq, xfer_start, tx_word_valid;
  logic [31:0] bus_rdata, tx_word_data;
  logic [3:0]  cs_n;
  logic [12:0] burst_bits;
  logic        tx_word_ready = 0, rx_word_valid = 0, xfer_done = 0;
  logic [31:0] rx_word_data = '0;

  int  errors = 0, checks = 0;
  bit  eng_on = 0, hold = 0, finished = 0;
  logic [31:0] held = '0;

  always #2.5 clk = ~clk;

  spim_csr_front #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u_spim_csr_front (.*);

  // engine model: take word, then return its inverse with done
  always @(negedge clk) begin
    rx_word_valid <= 1'b0; xfer_done <= 1'b0; tx_word_ready <= 1'b0;
    if (hold) begin
      rx_word_valid <= 1'b1; rx_word_data <= ~held; xfer_done <= 1'b1; hold <= 1'b0;
    end else if (tx_word_ready) begin
      hold <= 1'b1;
    end else if (eng_on && tx_word_valid) begin
      tx_word_ready <= 1'b1; held <= tx_word_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [11:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output logic err);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    rd = bus_rdata; err = bus_err;
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    logic [31:0] r; logic e;
    acc(1'b1, 12'(i*4), 4'hF, d, r, e);
  endtask

  task automatic rdr(input int i, output logic [31:0] d);
    logic e;
    acc(1'b0, 12'(i*4), 4'hF, 32'h0, d, e);
  endtask

  function automatic logic [31:0] ctl(bit en, bit xch, bit smc, logic [3:0] m, logic [1:0] s);
    return {10'd0, 12'd7, s, m, 1'b0, smc, xch, en};
  endfunction

  function automatic logic [31:0] exp_stat(int txc, int rxc, bit ovf, bit tc);
    logic [31:0] v = '0;
    v[0] = (txc == 0); v[1] = (txc < DEPTH); v[2] = (txc == DEPTH);
    v[3] = (rxc != 0); v[4] = (rxc == DEPTH); v[5] = ovf; v[6] = tc;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w[5];
    logic e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    rdr(5, d); chk(d == 32'h3, "R2 status", d, 32'h3);
    chk(cs_n == 4'hF && irq == 0, "R2 cs_n/irq", {27'd0, irq, cs_n}, 32'hF);
    rdr(2, d); chk(d == 0, "R2 ctrl", d, 0);

    // R1 bad accesses
    acc(1'b0, 12'h01C, 4'hF, 0, d, e); chk(e && d == 0, "R1 index 7", {e, d[30:0]}, 32'h8000_0000);
    acc(1'b1, 12'h010, 4'h3, 32'h7F, d, e); chk(e, "R1 partial err", {31'd0, e}, 1);
    acc(1'b1, 12'h012, 4'hF, 32'h7F, d, e); chk(e, "R1 misaligned err", {31'd0, e}, 1);
    rdr(4, d); chk(d == 0, "R1 ignored write", d, 0);

    // R6 write while disabled dropped
    wr(1, 32'h1111_1111); rdr(5, d); chk(d == 32'h3, "R6 disabled drop", d, 32'h3);

    // R9 chip selects
    wr(2, ctl(1, 0, 0, 4'b0100, 2'd2)); chk(cs_n == 4'b1011, "R9 cs ch2", {28'd0, cs_n}, 32'hB);
    wr(2, ctl(1, 0, 0, 4'b0001, 2'd0)); chk(cs_n == 4'b1110, "R9 cs ch0", {28'd0, cs_n}, 32'hE);
    chk(burst_bits == 13'd8, "R13 burst bits", {19'd0, burst_bits}, 8);

    // R3/R6/R8 random batches, engine idle
    for (int round = 0; round < 8; round++) begin
      int n = $urandom_range(0, 6);
      int txc = 0;
      wr(2, 32'h0);
      wr(2, ctl(1, 0, 0, 4'b0001, 2'd0));
      for (int k = 0; k < n; k++) begin
        wr(1, $urandom());
        if (txc < DEPTH) txc++;
      end
      rdr(5, d); chk(d == exp_stat(txc, 0, 0, 0), "R3 random status", d, exp_stat(txc, 0, 0, 0));
    end

    // R4 interrupt
    wr(2, 32'h0); wr(2, ctl(1, 0, 0, 4'b0001, 2'd0));
    wr(4, 32'h1); chk(irq == 1, "R4 irq tx empty", {31'd0, irq}, 1);
    wr(4, 32'h8); chk(irq == 0, "R4 irq rx empty", {31'd0, irq}, 0);

    // R12 exchange start, R13 order and done, R14 overflow
    eng_on = 1;
    for (int k = 0; k < 4; k++) begin w[k] = $urandom(); wr(1, w[k]); end
    rdr(5, d); chk(d == exp_stat(4, 0, 0, 0), "R12 no start yet", d, exp_stat(4, 0, 0, 0));
    wr(2, ctl(1, 1, 0, 4'b0001, 2'd0));
    repeat (30) @(negedge clk);
    rdr(5, d); chk(d == exp_stat(0, 4, 0, 1), "R12/R13 drained", d, exp_stat(0, 4, 0, 1));
    rdr(2, d); chk(d[1] == 0, "R13 exchange cleared", d, ctl(1, 0, 0, 4'b0001, 2'd0));
    w[4] = $urandom(); wr(1, w[4]);
    wr(2, ctl(1, 1, 0, 4'b0001, 2'd0));
    repeat (12) @(negedge clk);
    rdr(5, d); chk(d == exp_stat(0, 4, 1, 1), "R14 overflow", d, exp_stat(0, 4, 1, 1));
    wr(5, 32'h20); rdr(5, d); chk(d == exp_stat(0, 4, 0, 1), "R5 clear overflow", d, exp_stat(0, 4, 0, 1));
    wr(5, 32'hFFFF_FFFF); rdr(5, d); chk(d == exp_stat(0, 4, 0, 0), "R5 clear tc only", d, exp_stat(0, 4, 0, 0));
    for (int k = 0; k < 4; k++) begin
      rdr(0, d); chk(d == ~w[k], "R7/R13 rx order", d, ~w[k]);
    end
    rdr(0, d); chk(d == 0, "R7 rx empty read", d, 0);
    rdr(1, d); chk(d == 0, "R7 tx read", d, 0);
    rdr(6, d); chk(d == 0, "R7 msg read", d, 0);

    // R10 immediate mode
    wr(2, ctl(1, 0, 1, 4'b0001, 2'd0));
    w[0] = $urandom(); wr(1, w[0]);
    repeat (10) @(negedge clk);
    rdr(0, d); chk(d == ~w[0], "R10 immediate start", d, ~w[0]);

    // R11 raise immediate with data queued
    wr(2, ctl(1, 0, 0, 4'b0001, 2'd0)); wr(5, 32'h40);
    w[1] = $urandom(); w[2] = $urandom(); wr(1, w[1]); wr(1, w[2]);
    repeat (10) @(negedge clk);
    rdr(5, d); chk(d == exp_stat(2, 0, 0, 0), "R11 held", d, exp_stat(2, 0, 0, 0));
    wr(2, ctl(1, 0, 1, 4'b0001, 2'd0));
    repeat (20) @(negedge clk);
    rdr(0, d); chk(d == ~w[1], "R11 first", d, ~w[1]);
    rdr(0, d); chk(d == ~w[2], "R11 second", d, ~w[2]);

    // R7 disabled rx read, R8 reset on disable
    eng_on = 0;
    wr(4, 32'h7F); wr(1, 32'h5); wr(2, 32'h0);
    rdr(5, d); chk(d == 32'h3, "R8 status reset", d, 32'h3);
    rdr(4, d); chk(d == 0, "R8 ien reset", d, 0);
    chk(cs_n == 4'hF, "R8 cs reset", {28'd0, cs_n}, 32'hF);
    rdr(0, d); chk(d == 0, "R7 disabled rx read", d, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule